// File: doc/BRIEF.md
# Time-Aware Transmit Gate Sequencer

This block runs a repeating transmit gate schedule for one Ethernet egress port. A command memory holds two schedule buffers. Each command word pairs an 8-bit per-priority transmit-allow mask with a duration. The duration is a count of fetch units: bytes at gigabit speed, nibbles at 10/100 speed. The MAC side signals each unit with a one-clock strobe, so the sequencer itself does not depend on link speed.

An external periodic timer gives a cycle-start pulse. On that pulse the sequencer restarts at the first entry of the active buffer, drives its mask and counts down its duration. It then moves to the next entry. A zero duration ends the list, and that entry's mask is held until the next cycle. Software writes the idle buffer through a write port and requests it with a select input. The switch takes effect at the next cycle-start pulse. Two sticky flags report a schedule that ran past the end of its buffer and a cycle that restarted before its list was complete.

Top module: `tas_gate_sequencer`

## Requirements
- R1: After reset, `gate_mask` is 8'hFF, `active_buf` is 0, and both error flags are 0.
- R2: While `glb_en` or `port_en` is low, `gate_mask` is 8'hFF one clock later. Cycle-start pulses have no effect: `active_buf` and the error flags do not change. After re-enabling, the mask stays 8'hFF until the next cycle-start pulse.
- R3: A command word holds the allow mask in bits 7:0 and the fetch count in bits 21:8. The write address is {buffer, index}: `wr_addr[6]` selects the buffer and `wr_addr[5:0]` the entry. A cycle-start pulse makes the mask of entry 0 of the active buffer appear on `gate_mask` at the second clock edge after the pulse is sampled.
- R4: An entry's mask is held for exactly as many `fetch_tick` strobes as its count. Clocks without a strobe do not count. The next entry's mask appears one clock after the strobe that ends the count. A strobe in that load clock is not counted.
- R5: An entry with a nonzero count below 16 is held for 16 strobes.
- R6: An entry with count 0 ends the list. Its mask is held, whatever the strobes do, until the next cycle-start pulse.
- R7: `buf_sel` only requests a buffer. `active_buf` takes the value of `buf_sel` at a cycle-start pulse and at no other time, and entries are read from that buffer.
- R8: If the count of the last entry (index 63) of the active buffer expires, `addr_err` is set and stays set until reset. The mask of that last entry is held until the next cycle-start pulse.
- R9: A cycle-start pulse that arrives while the list has not ended sets `cnt_err`, which stays set until reset. The new cycle still starts from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Switch-wide gate scheduling enable |
| port_en | input | 1 | Enable for this port |
| wr_en | input | 1 | Command memory write strobe |
| wr_addr | input | 7 | {buffer, entry index} |
| wr_data | input | 22 | Command word: count 21:8, mask 7:0 |
| buf_sel | input | 1 | Requested schedule buffer |
| cycle_start | input | 1 | One-clock pulse from the cycle timer |
| fetch_tick | input | 1 | One-clock strobe per transmitted fetch unit |
| gate_mask | output | 8 | Per-priority transmit allow |
| active_buf | output | 1 | Buffer currently executed |
| addr_err | output | 1 | Sticky: list ran past the buffer end |
| cnt_err | output | 1 | Sticky: cycle restarted with entries pending |

## Verification
The bench targets the off-by-one points of the countdown. It checks the mask one strobe before and one clock after the expiry, with idle clocks placed between strobes. An engine that reloads a clock early, or counts idle clocks, shows the next mask too soon. It also checks the clamp of a short count to 16 and the hold on a zero-count terminator, which a wrong design would either skip past or run through into stale entries. A buffer request made mid-cycle must leave `active_buf` and the mask unchanged until the next pulse. A full 64-entry walk must raise the address error only on the last expiry. An early restart must raise the count error without a clean restart from IDLE doing the same. Cycle-start pulses while disabled must not switch buffers.

// File: rtl/tas_seq_pkg.sv
package tas_seq_pkg;
  localparam int MASK_W  = 8;
  localparam int CNT_W   = 14;
  localparam int CNT_LSB = 8;
  localparam int CMD_W   = CNT_LSB + CNT_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;

  function automatic logic [CNT_W-1:0] cmd_cnt(input logic [CMD_W-1:0] w);
    return w[CMD_W-1:CNT_LSB];
  endfunction

  function automatic logic [MASK_W-1:0] cmd_mask(input logic [CMD_W-1:0] w);
    return w[MASK_W-1:0];
  endfunction

  // short nonzero durations are raised to the floor value
  function automatic logic [CNT_W-1:0] eff_cnt(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] floor_c);
    if (c != '0 && c < floor_c) return floor_c;
    return c;
  endfunction
endpackage

// File: rtl/tas_cmd_ram.sv
module tas_cmd_ram
  import tas_seq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [$clog2(2*DEPTH)-1:0] wr_addr,
  input  logic [CMD_W-1:0]           wr_data,
  input  logic                       rd_buf,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [CMD_W-1:0]           rd_data
);
  localparam int WORDS = 2 * DEPTH;

  logic [CMD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[{rd_buf, rd_idx}];
endmodule

// File: rtl/tas_buf_ctrl.sv
module tas_buf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ev,
  input  logic sel_req,
  output logic active_buf
);
  always_ff @(posedge clk) begin
    if (!rst_n)        active_buf <= 1'b0;
    else if (start_ev) active_buf <= sel_req;
  end

  // R7: the executed buffer changes only on a cycle start
  a_r7_swap_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ev |=> $stable(active_buf));
endmodule

// File: rtl/tas_slot_engine.sv
module tas_slot_engine
  import tas_seq_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MIN_CNT = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     cycle_start,
  input  logic                     fetch_tick,
  input  logic [CMD_W-1:0]         cmd,
  output logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     start_ev,
  output logic [MASK_W-1:0]        gate_mask,
  output logic                     addr_err,
  output logic                     cnt_err
);
  localparam int                IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  MIN_C = CNT_W'(MIN_CNT);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] ptr;

  // named events
  logic ld_ev, expire_ev, adv_ev, overrun_ev, pending;
  assign start_ev   = en && cycle_start;
  assign pending    = (state == ST_LOAD) || (state == ST_RUN);
  assign ld_ev      = en && !start_ev && (state == ST_LOAD);
  assign expire_ev  = en && !start_ev && (state == ST_RUN) && fetch_tick && (cnt_q == 1);
  assign overrun_ev = expire_ev && (ptr == LAST);
  assign adv_ev     = expire_ev && (ptr != LAST);
  assign rd_idx     = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt_q     <= '0;
      ptr       <= '0;
      gate_mask <= '1;
      addr_err  <= 1'b0;
      cnt_err   <= 1'b0;
    end else if (!en) begin
      state     <= ST_IDLE;
      gate_mask <= '1;
    end else if (start_ev) begin
      state <= ST_LOAD;
      ptr   <= '0;
      if (pending) cnt_err <= 1'b1;
    end else begin
      unique case (state)
        ST_LOAD: begin
          gate_mask <= cmd_mask(cmd);
          cnt_q     <= eff_cnt(cmd_cnt(cmd), MIN_C);
          state     <= (cmd_cnt(cmd) == '0) ? ST_HOLD : ST_RUN;
        end
        ST_RUN: begin
          if (overrun_ev) begin
            addr_err <= 1'b1;
            cnt_q    <= '0;
            state    <= ST_HOLD;
          end else if (adv_ev) begin
            cnt_q <= '0;
            ptr   <= ptr + 1'b1;
            state <= ST_LOAD;
          end else if (fetch_tick) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R4: a running entry never sits at zero count
  a_r4_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (cnt_q != '0));
  // R4: an expiry leads straight to a load or to the hold state
  a_r4_expire_next: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> (state == ST_LOAD) && (ptr != '0));
  // R5: loaded nonzero counts are at least the floor
  a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ev && cmd_cnt(cmd) != '0) |=> (cnt_q >= MIN_C));
  // R6: the terminator mask holds until a new cycle
  a_r6_hold_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cycle_start && state == ST_HOLD) |=> $stable(gate_mask));
  // R8 and R9: sticky error flags
  a_r8_addr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> addr_err);
  a_r9_cnt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |=> cnt_err);
endmodule

// File: rtl/tas_gate_sequencer.sv
module tas_gate_sequencer
  import tas_seq_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MIN_CNT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       glb_en,
  input  logic                       port_en,
  input  logic                       wr_en,
  input  logic [$clog2(2*DEPTH)-1:0] wr_addr,
  input  logic [CMD_W-1:0]           wr_data,
  input  logic                       buf_sel,
  input  logic                       cycle_start,
  input  logic                       fetch_tick,
  output logic [MASK_W-1:0]          gate_mask,
  output logic                       active_buf,
  output logic                       addr_err,
  output logic                       cnt_err
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             en;
  logic             start_ev;
  logic [IDX_W-1:0] rd_idx;
  logic [CMD_W-1:0] rd_cmd;

  assign en = glb_en && port_en;

  tas_cmd_ram #(.DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_buf  (active_buf),
    .rd_idx  (rd_idx),
    .rd_data (rd_cmd)
  );

  tas_buf_ctrl u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ev   (start_ev),
    .sel_req    (buf_sel),
    .active_buf (active_buf)
  );

  tas_slot_engine #(.DEPTH(DEPTH), .MIN_CNT(MIN_CNT)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .cycle_start (cycle_start),
    .fetch_tick  (fetch_tick),
    .cmd         (rd_cmd),
    .rd_idx      (rd_idx),
    .start_ev    (start_ev),
    .gate_mask   (gate_mask),
    .addr_err    (addr_err),
    .cnt_err     (cnt_err)
  );

  // R2: while disabled, pulses change no buffer and raise no error, gates open
  a_r2_disabled_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(active_buf) && !$rose(cnt_err) && (gate_mask == '1));
endmodule

// File: tb/sim_tas_gate_sequencer.sv
module sim_tas_gate_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b1, port_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [21:0] wr_data = '0;
  logic        buf_sel = 1'b0, cycle_start = 1'b0, fetch_tick = 1'b0;
  logic [7:0]  gate_mask;
  logic        active_buf, addr_err, cnt_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tas_gate_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .port_en(port_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .buf_sel(buf_sel),
    .cycle_start(cycle_start), .fetch_tick(fetch_tick), .gate_mask(gate_mask),
    .active_buf(active_buf), .addr_err(addr_err), .cnt_err(cnt_err)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input bit b, input int idx, input int cnt, input logic [7:0] m);
    wr_en = 1'b1; wr_addr = {b, 6'(idx)}; wr_data = {14'(cnt), m};
    step();
    wr_en = 1'b0;
  endtask

  // pulse, then pass the load edge
  task automatic pulse_start();
    cycle_start = 1'b1; step(); cycle_start = 1'b0; step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin fetch_tick = 1'b1; step(); end
    fetch_tick = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 mask", gate_mask, 8'hFF);
    check("R1 active", active_buf, 0);
    check("R1 errors", {addr_err, cnt_err}, 0);
  endtask

  task automatic t_sequence();
    put(0, 0, 20, 8'h01); put(0, 1, 16, 8'h02); put(0, 2, 0, 8'h04);
    put(0, 3, 30, 8'h08);
    pulse_start();
    check("R3 first mask", gate_mask, 8'h01);
    ticks(10); step(); step();
    ticks(9); step();
    check("R4 before expiry", gate_mask, 8'h01);
    ticks(1);
    check("R4 load clock", gate_mask, 8'h01);
    step();
    check("R4 next entry", gate_mask, 8'h02);
    ticks(16); step();
    check("R6 terminator mask", gate_mask, 8'h04);
    ticks(50);
    check("R6 held past end", gate_mask, 8'h04);
  endtask

  task automatic t_floor();
    put(0, 0, 3, 8'h10); put(0, 1, 0, 8'h20);
    pulse_start();
    check("R9 no error from ended list", cnt_err, 0);
    check("R5 short entry", gate_mask, 8'h10);
    ticks(15); step();
    check("R5 held to 15", gate_mask, 8'h10);
    ticks(1); step();
    check("R5 released at 16", gate_mask, 8'h20);
  endtask

  task automatic t_swap();
    put(1, 0, 0, 8'h33);
    buf_sel = 1'b1;
    step(); step(); step();
    check("R7 no early swap", active_buf, 0);
    check("R7 mask unchanged", gate_mask, 8'h20);
    pulse_start();
    check("R7 swapped", active_buf, 1);
    check("R7 new buffer read", gate_mask, 8'h33);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 64; i++) put(0, i, 16, 8'(i));
    buf_sel = 1'b0;
    pulse_start();
    check("R7 back to 0", active_buf, 0);
    check("R3 entry 0", gate_mask, 8'h00);
    for (int i = 0; i < 63; i++) begin ticks(16); step(); end
    check("R8 last entry", gate_mask, 8'h3F);
    check("R8 no early flag", addr_err, 0);
    ticks(16);
    check("R8 flag", addr_err, 1);
    ticks(5);
    check("R8 last mask held", gate_mask, 8'h3F);
  endtask

  task automatic t_disable();
    port_en = 1'b0; step();
    check("R2 port off open", gate_mask, 8'hFF);
    buf_sel = 1'b1;
    pulse_start();
    check("R2 no swap", active_buf, 0);
    check("R2 no count error", cnt_err, 0);
    port_en = 1'b1; glb_en = 1'b0; step();
    check("R2 global off open", gate_mask, 8'hFF);
    glb_en = 1'b1; step(); step();
    check("R2 open until start", gate_mask, 8'hFF);
  endtask

  task automatic t_restart();
    put(1, 0, 100, 8'h44); put(1, 1, 0, 8'h55);
    pulse_start();
    check("R9 clean start", cnt_err, 0);
    check("R7 buffer 1 mask", gate_mask, 8'h44);
    ticks(10);
    pulse_start();
    check("R9 flag", cnt_err, 1);
    check("R9 restarted", gate_mask, 8'h44);
    ticks(99); step();
    check("R9 full count after restart", gate_mask, 8'h44);
    ticks(1); step();
    check("R9 next entry", gate_mask, 8'h55);
    check("R8 still set", addr_err, 1);
  endtask

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_sequence();
    t_floor();
    t_swap();
    t_overrun();
    t_disable();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule